// File: doc/BRIEF.md
# Configurable Bidirectional I/O Port

This block is one eight-pin general-purpose I/O port that a processor core controls through a small register window. It has two storage bits for each pin: a direction bit and a value bit. Together they pick one of four pin modes: floating input, input with a weak pull-up, output driven low, or output driven high. A third, read-only register returns the pin levels after a two-flop synchroniser. The block drives the pad cell through per-pin output-enable, output-value and pull-up-enable lines. Input conditioning and the pad itself sit outside the block.

The register window takes three consecutive addresses that start at a parameterised base. A parameter mask marks some pins as input-only; by default these are the two top pins. Any direction bit written to one of them is dropped, so that pin can never be driven. One pin, bit 7 by default, also acts as a stop request. Writing a one to its value bit sends a one-cycle halt pulse to the clock controller, and the stored bit stays zero.

Top module: `gpio_port`

## Requirements
- R1: After reset, the value and direction registers read 0x00, every pad_oe and pad_pullup bit is 0, and halt_req is 0.
- R2: A pin whose direction bit is 0 and value bit is 0 (mode code {dir,val}=2'b00) has pad_oe=0 and pad_pullup=0.
- R3: A pin with {dir,val}=2'b01 has pad_oe=0 and pad_pullup=1. pad_oe and pad_pullup are never both 1 on the same pin.
- R4: A pin with dir=1 has pad_oe=1, pad_pullup=0 and pad_out equal to its value bit (2'b10 drives 0, 2'b11 drives 1). A pin with dir=0 has pad_out=0.
- R5: The value register is at BASE_ADDR, the direction register at BASE_ADDR+1 and the pin register at BASE_ADDR+2 (default 0xD4/0xD5/0xD6). A write to any other address, or to the pin register, changes nothing. A read of any other address returns 0x00.
- R6: On the input-only pins (mask 0xC0 by default, bits 6 and 7), a direction bit written as 1 is discarded. These direction bits always read 0, and these pins never assert pad_oe.
- R7: A write to the value register with bit 7 set makes halt_req high for exactly the one cycle after the write edge. Value bit 7 reads 0 afterwards. A write with bit 7 clear gives no pulse.
- R8: A read of the pin register returns pad_in as sampled two clock edges earlier. A change on pad_in is not seen after one edge and is seen after two.
- R9: Reads of the value and direction registers return the stored contents, whatever levels are on the pins.
- R10: bus_wr with bus_sel low writes nothing, and bus_rdata is 0x00 while bus_sel is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data, combinational from address |
| pad_in | input | WIDTH | Raw pin levels from pads |
| pad_oe | output | WIDTH | Per-pin output enable |
| pad_out | output | WIDTH | Per-pin driven level |
| pad_pullup | output | WIDTH | Per-pin weak pull-up enable |
| halt_req | output | 1 | One-cycle halt request pulse |

## Verification
The bench goes after the input-only pins first. A design that masked only the readback, and not the stored direction bit, would drive pins 6 and 7 onto external sources. It then writes value bit 7 to check for a single halt pulse. A design with this wrong would keep halt asserted, or read back bit 7 as 1, which turns on a pull-up on a pin that should float. It steps pad_in through the synchroniser edge by edge, which catches a chain that is one stage short or one stage long. It also writes to neighbour addresses and with the strobe low, which exposes a loose address decode that corrupts the value or direction registers.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // Pin mode code formed as {direction bit, value bit}
  typedef enum logic [1:0] {
    MODE_FLOAT  = 2'b00,
    MODE_PULLUP = 2'b01,
    MODE_DRIVE0 = 2'b10,
    MODE_DRIVE1 = 2'b11
  } pin_mode_e;

  typedef enum logic [1:0] {
    SEL_VALUE = 2'd0,
    SEL_DIR   = 2'd1,
    SEL_PIN   = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  function automatic pin_mode_e pin_mode(input logic dir_bit, input logic val_bit);
    return pin_mode_e'({dir_bit, val_bit});
  endfunction

  function automatic logic mode_drives(input pin_mode_e m);
    return (m == MODE_DRIVE0) || (m == MODE_DRIVE1);
  endfunction

  function automatic logic mode_pulls(input pin_mode_e m);
    return m == MODE_PULLUP;
  endfunction

endpackage

// File: rtl/gpio_port_decode.sv
module gpio_port_decode #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 'hD4
) (
  input  logic [ADDR_W-1:0]         addr,
  output gpio_port_pkg::reg_sel_e   sel
);
  import gpio_port_pkg::*;

  localparam logic [ADDR_W-1:0] A_VALUE = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(BASE_ADDR + 1);
  localparam logic [ADDR_W-1:0] A_PIN   = ADDR_W'(BASE_ADDR + 2);

  always_comb begin
    if (addr == A_VALUE)    sel = SEL_VALUE;
    else if (addr == A_DIR) sel = SEL_DIR;
    else if (addr == A_PIN) sel = SEL_PIN;
    else                    sel = SEL_NONE;
  end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int unsigned WIDTH         = 8,
  parameter logic [WIDTH-1:0] IN_ONLY  = 8'hC0,
  parameter bit          HALT_EN       = 1'b1,
  parameter int unsigned HALT_BIT      = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_value,
  input  logic             wr_dir,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] value_q,
  output logic [WIDTH-1:0] dir_q,
  output logic             halt_req
);

  localparam logic [WIDTH-1:0] HALT_MASK =
    HALT_EN ? (WIDTH'(1) << HALT_BIT) : '0;

  logic [WIDTH-1:0] value_next;
  logic [WIDTH-1:0] dir_next;

  always_comb begin
    value_next = wdata & ~HALT_MASK;   // halt bit never retained
    dir_next   = wdata & ~IN_ONLY;     // input-only pins cannot turn on
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= '0;
      dir_q   <= '0;
    end else begin
      if (wr_value) value_q <= value_next;
      if (wr_dir)   dir_q   <= dir_next;
    end
  end

  generate
    if (HALT_EN) begin : g_halt
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) halt_req <= 1'b0;
        else        halt_req <= wr_value && wdata[HALT_BIT];
      end
    end else begin : g_nohalt
      assign halt_req = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stg[STAGES-1];

endmodule

// File: rtl/gpio_port_padctl.sv
module gpio_port_padctl #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] value_q,
  input  logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_pullup
);
  import gpio_port_pkg::*;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      pin_mode_e mode;
      assign mode          = pin_mode(dir_q[i], value_q[i]);
      assign pad_oe[i]     = mode_drives(mode);
      assign pad_out[i]    = (mode == MODE_DRIVE1);
      assign pad_pullup[i] = mode_pulls(mode);
    end
  endgenerate

endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int unsigned WIDTH        = 8,
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned BASE_ADDR    = 'hD4,
  parameter logic [WIDTH-1:0] IN_ONLY = 8'hC0,
  parameter bit          HALT_EN      = 1'b1,
  parameter int unsigned HALT_BIT     = 7,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_pullup,
  output logic              halt_req
);
  import gpio_port_pkg::*;

  reg_sel_e         sel;
  logic             wr_value_evt;
  logic             wr_dir_evt;
  logic [WIDTH-1:0] value_q;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] pin_sync;

  gpio_port_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  assign wr_value_evt = bus_sel && bus_wr && (sel == SEL_VALUE);
  assign wr_dir_evt   = bus_sel && bus_wr && (sel == SEL_DIR);

  gpio_port_regs #(
    .WIDTH(WIDTH), .IN_ONLY(IN_ONLY), .HALT_EN(HALT_EN), .HALT_BIT(HALT_BIT)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_value (wr_value_evt),
    .wr_dir   (wr_dir_evt),
    .wdata    (bus_wdata),
    .value_q  (value_q),
    .dir_q    (dir_q),
    .halt_req (halt_req)
  );

  gpio_port_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (pin_sync)
  );

  gpio_port_padctl #(.WIDTH(WIDTH)) u_pad (
    .value_q    (value_q),
    .dir_q      (dir_q),
    .pad_oe     (pad_oe),
    .pad_out    (pad_out),
    .pad_pullup (pad_pullup)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      unique case (sel)
        SEL_VALUE: bus_rdata = value_q;
        SEL_DIR:   bus_rdata = dir_q;
        SEL_PIN:   bus_rdata = pin_sync;
        default:   bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int unsigned WIDTH        = 8,
  parameter logic [WIDTH-1:0] IN_ONLY = 8'hC0,
  parameter int unsigned HALT_BIT     = 7,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] bus_wdata,
  input logic [WIDTH-1:0] pad_in,
  input logic [WIDTH-1:0] pad_oe,
  input logic [WIDTH-1:0] pad_pullup,
  input logic             halt_req,
  input logic             wr_value_evt,
  input logic             wr_dir_evt,
  input logic [WIDTH-1:0] dir_q,
  input logic [WIDTH-1:0] pin_sync
);

  logic [3:0] arm_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        arm_cnt <= '0;
    else if (arm_cnt < 4'(SYNC_STAGES)) arm_cnt <= arm_cnt + 4'd1;
  end

  p_input_only_undriven_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & IN_ONLY) == '0);

  p_oe_pull_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_pullup) == '0);

  p_halt_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |=> !halt_req);

  p_halt_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> $past(wr_value_evt && bus_wdata[HALT_BIT]));

  p_dir_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir_evt |=> $stable(dir_q));

  p_sync_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_cnt == 4'(SYNC_STAGES)) |-> (pin_sync == $past(pad_in, SYNC_STAGES)));

endmodule

bind gpio_port gpio_port_chk #(
  .WIDTH(WIDTH), .IN_ONLY(IN_ONLY), .HALT_BIT(HALT_BIT), .SYNC_STAGES(SYNC_STAGES)
) u_chk (.*);

// File: tb/gpio_port_test.sv
module gpio_port_test;

  localparam logic [7:0] A_VAL = 8'hD4;
  localparam logic [7:0] A_DIR = 8'hD5;
  localparam logic [7:0] A_PIN = 8'hD6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_oe, pad_out, pad_pullup;
  logic       halt_req;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  gpio_port uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_pullup(pad_pullup), .halt_req(halt_req)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d, input logic sel = 1'b1);
    @(negedge clk);
    bus_sel = sel; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    bus_read(A_VAL, d); check("R1", "value after reset", d, 8'h00);
    bus_read(A_DIR, d); check("R1", "dir after reset", d, 8'h00);
    check("R1", "oe after reset", pad_oe, 8'h00);
    check("R1", "pullup after reset", pad_pullup, 8'h00);
    check("R1", "halt after reset", {7'd0, halt_req}, 8'h00);
  endtask

  task automatic t_modes();
    bus_write(A_DIR, 8'h0F);
    bus_write(A_VAL, 8'h35);
    check("R4", "oe on driven pins", pad_oe, 8'h0F);
    check("R4", "out levels", pad_out, 8'h05);
    check("R3", "pullup on 01 pins", pad_pullup, 8'h30);
    check("R2", "float pins 6,7 oe", pad_oe & 8'hC0, 8'h00);
    check("R2", "float pins 6,7 pullup", pad_pullup & 8'hC0, 8'h00);
  endtask

  task automatic t_input_only();
    logic [7:0] d;
    bus_write(A_DIR, 8'hFF);
    bus_read(A_DIR, d); check("R6", "dir readback masked", d, 8'h3F);
    check("R6", "oe never on input-only", pad_oe, 8'h3F);
    check("R6", "out levels", pad_out, 8'h35);
  endtask

  task automatic t_halt();
    logic [7:0] d;
    bus_write(A_VAL, 8'h80);
    check("R7", "halt pulse high", {7'd0, halt_req}, 8'h01);
    @(negedge clk);
    check("R7", "halt pulse ends", {7'd0, halt_req}, 8'h00);
    bus_read(A_VAL, d); check("R7", "bit7 not kept", d, 8'h00);
    bus_write(A_DIR, 8'h00);
    bus_write(A_VAL, 8'h40);
    check("R7", "no halt on bit7 clear", {7'd0, halt_req}, 8'h00);
    bus_read(A_VAL, d); check("R7", "value stored", d, 8'h40);
    check("R3", "pullup on pin 6", pad_pullup, 8'h40);
  endtask

  task automatic t_sync();
    logic [7:0] d;
    @(negedge clk);
    pad_in = 8'hA5;
    bus_read(A_PIN, d); check("R8", "pin before edges", d, 8'h00);
    @(negedge clk);
    bus_read(A_PIN, d); check("R8", "pin after one edge", d, 8'h00);
    @(negedge clk);
    bus_read(A_PIN, d); check("R8", "pin after two edges", d, 8'hA5);
  endtask

  task automatic t_reg_vs_pin();
    logic [7:0] d;
    pad_in = 8'hFF;
    repeat (3) @(negedge clk);
    bus_read(A_VAL, d); check("R9", "value ignores pins", d, 8'h40);
    bus_read(A_DIR, d); check("R9", "dir ignores pins", d, 8'h00);
    bus_read(A_PIN, d); check("R9", "pin shows pins", d, 8'hFF);
  endtask

  task automatic t_addr();
    logic [7:0] d;
    bus_write(8'hD7, 8'hFF);
    bus_write(8'hD3, 8'hFF);
    bus_write(A_PIN, 8'h12);
    bus_read(A_VAL, d); check("R5", "value after stray writes", d, 8'h40);
    bus_read(A_DIR, d); check("R5", "dir after stray writes", d, 8'h00);
    bus_read(8'hD7, d); check("R5", "unmapped read", d, 8'h00);
    check("R5", "oe after stray writes", pad_oe, 8'h00);
  endtask

  task automatic t_nosel();
    logic [7:0] d;
    bus_write(A_DIR, 8'h3F, 1'b0);
    bus_write(A_VAL, 8'h0F, 1'b0);
    bus_read(A_DIR, d); check("R10", "dir unselected write", d, 8'h00);
    bus_read(A_VAL, d); check("R10", "value unselected write", d, 8'h40);
    bus_addr = A_VAL; #1;
    check("R10", "rdata idle", bus_rdata, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_modes();
    t_input_only();
    t_halt();
    t_sync();
    t_reg_vs_pin();
    t_addr();
    t_nosel();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule